// File: doc/BRIEF.md
# Watermark Audio Channel FIFO

This block is a single channel of a multi-channel audio sample buffer. It stores up to 512 words of 32 bits in arrival order. One side pushes words and the other side pops them. A mode input decides the direction:

- **Capture:** the converter side fills the buffer and the system bus drains it.
- **Playback:** the bus fills the buffer and the converter side drains it.

Two 9-bit thresholds, an almost-full level and an almost-empty level, are held in one configuration word. The block compares the fill level against both thresholds. It drives one level-sensitive request toward the interrupt or DMA logic that sits outside it.

Software reads the raw read and write addresses through one status word. It computes free or used space by subtraction. For that reason the addresses run from 0 to 511 and wrap at 512. Equal addresses mean the buffer is empty unless the separate real-full flag is set. A one-cycle flush strobe discards all contents and returns both addresses to zero.

Top module: `audio_wm_fifo`

## Requirements
- R1: The buffer holds 512 words of 32 bits. `pop_data` always shows the oldest stored word, and words leave in the order they arrived.
- R2: A config write sets the almost-empty threshold from `cfg_wdata[24:16]` and the almost-full threshold from `cfg_wdata[8:0]`. `cfg_rdata` returns both fields in the same positions, with all other bits zero. After reset the config word reads 0x0000_01FF.
- R3: `ptr_status[25:16]` carries the read address and `ptr_status[9:0]` carries the write address. Each address is in the range 0 to 511 and advances by one per accepted pop or push, wrapping from 511 to 0. All other status bits are zero, and both addresses are zero after reset.
- R4: While `full` is low, the used word count is exact from the status word: wr−rd when wr≥rd, otherwise 512−rd+wr. The free count is 512 minus that value.
- R5: `empty` is high exactly when no words are held. `full` is high exactly when 512 words are held.
- R6: `almost_full` is high whenever the held word count is greater than or equal to the almost-full threshold.
- R7: `almost_empty` is high whenever the held word count is less than or equal to the almost-empty threshold.
- R8: `dreq` follows `almost_empty` when `playback` is 1, and follows `almost_full` when `playback` is 0.
- R9: A push while `full` is high is ignored, even if a pop happens in the same cycle. A pop while `empty` is high is ignored. Neither moves an address.
- R10: A `flush` pulse zeroes both addresses and the count at the next clock edge. Any push or pop in that same cycle is discarded.
- R11: A push and a pop in the same cycle, with the buffer neither full nor empty, both take effect and leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| playback | input | 1 | 1 selects playback direction, 0 selects capture |
| push | input | 1 | Store `push_data` this cycle |
| push_data | input | 32 | Word to store |
| pop | input | 1 | Remove the oldest word this cycle |
| pop_data | output | 32 | Oldest stored word |
| flush | input | 1 | One-cycle strobe that empties the buffer |
| cfg_wr | input | 1 | Load the threshold word |
| cfg_wdata | input | 32 | Threshold word to load |
| cfg_rdata | output | 32 | Current threshold word |
| ptr_status | output | 32 | Read and write addresses |
| full | output | 1 | Real full |
| empty | output | 1 | Real empty |
| almost_full | output | 1 | Count at or above the almost-full level |
| almost_empty | output | 1 | Count at or below the almost-empty level |
| dreq | output | 1 | Service request for the selected direction |

## Verification
A corrupted address or count appears at the ports on the clock edge after it happens. `ptr_status` then disagrees with the number of accepted transfers, and the flags or the request line switch one word early or late against a threshold. A wrong read address also shows as the wrong word on `pop_data` at the next pop. Because real-full and real-empty share the "addresses equal" condition, the bench fills the buffer completely and checks the wrap across address 511. Those are the only points where a missing full flag or a bad wrap becomes visible.

// File: rtl/wmf_pkg.sv
package wmf_pkg;
    parameter int unsigned DATA_W     = 32;
    parameter int unsigned ADDR_W     = 9;
    parameter int unsigned FIELD_W    = 10;
    parameter int unsigned THR_W      = 9;
    localparam int unsigned DEPTH     = 1 << ADDR_W;
    localparam int unsigned CNT_W     = ADDR_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] rd;
        logic [ADDR_W-1:0] wr;
        logic [CNT_W-1:0]  cnt;
        logic [THR_W-1:0]  ae_thr;
        logic [THR_W-1:0]  af_thr;
    } wmf_state_t;
endpackage

// File: rtl/wmf_store.sv
module wmf_store #(
    parameter int unsigned DATA_W = wmf_pkg::DATA_W,
    parameter int unsigned ADDR_W = wmf_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/wmf_ctrl.sv
module wmf_ctrl
    import wmf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              flush,
    input  logic              cfg_wr,
    input  logic [31:0]       cfg_wdata,
    output logic              wr_en,
    output wmf_state_t        state
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    wmf_state_t st_d, st_q;
    logic       full_now, empty_now, take_push, take_pop;

    always_comb begin
        st_d      = st_q;
        full_now  = (st_q.cnt == FULL_CNT);
        empty_now = (st_q.cnt == '0);
        take_push = push && !full_now && !flush;
        take_pop  = pop && !empty_now && !flush;

        if (cfg_wr) begin
            st_d.ae_thr = cfg_wdata[16 +: THR_W];
            st_d.af_thr = cfg_wdata[0 +: THR_W];
        end

        if (flush) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (take_push) begin
                st_d.wr = st_q.wr + 1'b1;
            end
            if (take_pop) begin
                st_d.rd = st_q.rd + 1'b1;
            end
            case ({take_push, take_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.af_thr <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en = take_push;
    assign state = st_q;
endmodule

// File: rtl/wmf_level.sv
module wmf_level #(
    parameter int unsigned CNT_W = wmf_pkg::CNT_W,
    parameter int unsigned THR_W = wmf_pkg::THR_W
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [THR_W-1:0] ae_thr,
    input  logic [THR_W-1:0] af_thr,
    input  logic             playback,
    output logic             almost_full,
    output logic             almost_empty,
    output logic             dreq
);
    always_comb begin
        almost_full  = (cnt >= CNT_W'(af_thr));
        almost_empty = (cnt <= CNT_W'(ae_thr));
        dreq         = playback ? almost_empty : almost_full;
    end
endmodule

// File: rtl/audio_wm_fifo.sv
module audio_wm_fifo
    import wmf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        playback,
    input  logic        push,
    input  logic [31:0] push_data,
    input  logic        pop,
    output logic [31:0] pop_data,
    input  logic        flush,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic [31:0] ptr_status,
    output logic        full,
    output logic        empty,
    output logic        almost_full,
    output logic        almost_empty,
    output logic        dreq
);
    localparam int unsigned PAD_W = FIELD_W - ADDR_W;

    wmf_state_t st;
    logic       wr_en;

    wmf_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .flush     (flush),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .wr_en     (wr_en),
        .state     (st)
    );

    wmf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (st.wr),
        .wdata (push_data),
        .raddr (st.rd),
        .rdata (pop_data)
    );

    wmf_level #(.CNT_W(CNT_W), .THR_W(THR_W)) i_level (
        .cnt          (st.cnt),
        .ae_thr       (st.ae_thr),
        .af_thr       (st.af_thr),
        .playback     (playback),
        .almost_full  (almost_full),
        .almost_empty (almost_empty),
        .dreq         (dreq)
    );

    always_comb begin
        ptr_status = '0;
        ptr_status[16 +: FIELD_W] = {{PAD_W{1'b0}}, st.rd};
        ptr_status[0 +: FIELD_W]  = {{PAD_W{1'b0}}, st.wr};
        cfg_rdata = '0;
        cfg_rdata[16 +: THR_W] = st.ae_thr;
        cfg_rdata[0 +: THR_W]  = st.af_thr;
        full  = (st.cnt == CNT_W'(DEPTH));
        empty = (st.cnt == '0);
    end
endmodule

// File: rtl/wmf_checker.sv
module wmf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        push,
    input logic        pop,
    input logic        flush,
    input logic        full,
    input logic        empty,
    input logic [31:0] ptr_status
);
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));                                                    // R5
    AST_FULL_ADDR_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (ptr_status[25:16] == ptr_status[9:0]));                     // R5
    AST_EMPTY_ADDR_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (ptr_status[25:16] == ptr_status[9:0]));                    // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !flush) |=> $stable(ptr_status[9:0]));               // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !flush) |=> $stable(ptr_status[25:16]));             // R9
    AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ptr_status == 32'd0 && empty));                            // R10
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_status[31:25] == 7'd0 && ptr_status[15:9] == 7'd0));             // R3
endmodule

bind audio_wm_fifo wmf_checker i_wmf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .pop        (pop),
    .flush      (flush),
    .full       (full),
    .empty      (empty),
    .ptr_status (ptr_status)
);

// File: tb/test_audio_wm_fifo.sv
module test_audio_wm_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        playback = 1'b0;
    logic        push = 1'b0;
    logic [31:0] push_data = '0;
    logic        pop = 1'b0;
    logic [31:0] pop_data;
    logic        flush = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata, ptr_status;
    logic        full, empty, almost_full, almost_empty, dreq;

    int n_checks = 0;
    int n_errors = 0;

    logic [31:0] m_q[$];
    int m_rd = 0, m_wr = 0, m_af = 511, m_ae = 0;

    always #4 clk = ~clk;

    audio_wm_fifo i_audio_wm_fifo (
        .clk(clk), .rst_n(rst_n), .playback(playback), .push(push),
        .push_data(push_data), .pop(pop), .pop_data(pop_data), .flush(flush),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ptr_status(ptr_status), .full(full), .empty(empty),
        .almost_full(almost_full), .almost_empty(almost_empty), .dreq(dreq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic step(input logic ps, input logic [31:0] pd, input logic pp, input logic fl);
        int sz;
        @(negedge clk);
        push = ps; push_data = pd; pop = pp; flush = fl;
        sz = m_q.size();
        if (pp && sz > 0) chk("R1 pop order", pop_data, m_q[0]);
        @(posedge clk);
        if (fl) begin
            m_q.delete(); m_rd = 0; m_wr = 0;
        end else begin
            if (pp && sz > 0) begin
                void'(m_q.pop_front()); m_rd = (m_rd + 1) % 512;
            end
            if (ps && sz < 512) begin
                m_q.push_back(pd); m_wr = (m_wr + 1) % 512;
            end
        end
        #1; push = 1'b0; pop = 1'b0; flush = 1'b0;
    endtask

    task automatic check_all(input string tag);
        int n, used;
        #1;
        n = m_q.size();
        chk({tag, " R3 status"}, ptr_status, (32'(m_rd) << 16) | 32'(m_wr));
        chk({tag, " R5 full"}, 32'(full), 32'(n == 512));
        chk({tag, " R5 empty"}, 32'(empty), 32'(n == 0));
        chk({tag, " R6 almost_full"}, 32'(almost_full), 32'(n >= m_af));
        chk({tag, " R7 almost_empty"}, 32'(almost_empty), 32'(n <= m_ae));
        chk({tag, " R8 dreq"}, 32'(dreq), playback ? 32'(n <= m_ae) : 32'(n >= m_af));
        if (!full) begin
            used = (ptr_status[9:0] >= ptr_status[25:16]) ?
                   int'(ptr_status[9:0]) - int'(ptr_status[25:16]) :
                   512 - int'(ptr_status[25:16]) + int'(ptr_status[9:0]);
            chk({tag, " R4 derived count"}, 32'(used), 32'(n));
        end
    endtask

    task automatic cfg_write(input logic [31:0] w);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = w;
        @(posedge clk);
        #1; cfg_wr = 1'b0;
        m_ae = int'(w[24:16]); m_af = int'(w[8:0]);
        #1;
        chk("R2 config readback", cfg_rdata, w & 32'h01FF_01FF);
    endtask

    task automatic t_reset;
        #1;
        chk("R2 reset config", cfg_rdata, 32'h0000_01FF);
        chk("R3 reset status", ptr_status, 32'h0);
        check_all("reset");
    endtask

    task automatic t_thresholds;
        cfg_write(32'hFE02_7E04);
        for (int i = 0; i < 6; i++) begin
            step(1'b1, 32'hA000_0000 + 32'(i), 1'b0, 1'b0);
            check_all("capture fill");
        end
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 32'h0, 1'b1, 1'b0);
            check_all("capture drain");
        end
    endtask

    task automatic t_full_and_ignore;
        for (int i = 0; i < 512; i++) step(1'b1, 32'h5500_0000 ^ 32'(i * 7), 1'b0, 1'b0);
        check_all("R5 at full");
        step(1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0);
        check_all("R9 push on full");
        step(1'b1, 32'hBAD0_0001, 1'b1, 1'b0);
        check_all("R9 push with pop on full");
        for (int i = 0; i < 511; i++) step(1'b0, 32'h0, 1'b1, 1'b0);
        check_all("R1 drained");
        step(1'b0, 32'h0, 1'b1, 1'b0);
        step(1'b0, 32'h0, 1'b1, 1'b0);
        check_all("R9 pop on empty");
    endtask

    task automatic t_wrap;
        step(1'b0, 32'h0, 1'b0, 1'b1);
        for (int i = 0; i < 500; i++) step(1'b1, 32'(i), 1'b0, 1'b0);
        for (int i = 0; i < 500; i++) step(1'b0, 32'h0, 1'b1, 1'b0);
        for (int i = 0; i < 20; i++) step(1'b1, 32'h7700_0000 + 32'(i), 1'b0, 1'b0);
        check_all("R3 wrapped address");
        chk("R4 playback free", 32'(int'(ptr_status[25:16]) - int'(ptr_status[9:0])), 32'd492);
    endtask

    task automatic t_simultaneous;
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 32'hC0DE_0000 + 32'(i), 1'b1, 1'b0);
            check_all("R11 push and pop");
        end
    endtask

    task automatic t_flush;
        step(1'b1, 32'h1234_5678, 1'b1, 1'b1);
        check_all("R10 flush");
        chk("R10 flush status zero", ptr_status, 32'h0);
        step(1'b1, 32'h0BAD_F00D, 1'b0, 1'b0);
        chk("R1 first word after flush", pop_data, 32'h0BAD_F00D);
        step(1'b0, 32'h0, 1'b1, 1'b0);
    endtask

    task automatic t_playback;
        playback = 1'b1;
        cfg_write(32'h0003_01FF);
        check_all("R8 playback empty");
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 32'hB000_0000 + 32'(i), 1'b0, 1'b0);
            check_all("R8 playback fill");
        end
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 32'h0, 1'b1, 1'b0);
            check_all("R7 playback drain");
        end
    endtask

    initial begin
        #(8 * 150000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_thresholds();
        t_full_and_ignore();
        t_wrap();
        t_simultaneous();
        t_flush();
        t_playback();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule